// File: doc/BRIEF.md
# Cascaded Power-Up Sequencer

This block drives three active-low power-up enables in a fixed chain. Each one asserts a programmed delay after two things are true: its own supply reports good, and the enable before it is already asserted. Stage 1 watches supply V0, stage 2 watches V1 and stage 3 watches V2. Nothing starts until V0 is good. A single disable bit with inverted sense (1 = sequencing off) holds every output inactive.

Delays are counted in 1 ms ticks. The ticks come from the clock through a per-stage prescaler of `TICK_DIV` cycles. A 2-bit code per stage selects a delay of `BASE_TICKS << code` ticks. With the defaults this gives 25, 50, 100 or 200 ms for codes 0 to 3.

If a supply in the chain drops, its stage and every later stage release their outputs on the next clock edge. Their counters go back to zero, so when the supply comes back each of those stages waits its full delay again.

Top module: `pwr_cascade_seq`

## Requirements
- R1: While `rstN` is low and on the first cycle after reset, all three bits of `pupN` are high.
- R2: While `cascadeDis` is 1, `pupN` is 3'b111 one edge later, including when outputs were already low.
- R3: While `supplyGood[0]` is 0, no output asserts, whatever the other supplies show.
- R4: Stage delay in clock cycles is `(BASE_TICKS << code) * TICK_DIV`, with code 0..3 giving 25, 50, 100 and 200 ticks by default. `pupN[0]` goes low exactly that many edges after `supplyGood[0]` rises with the block enabled.
- R5: The stage 2 (or stage 3) counter starts on the first edge at which the previous output is low and `supplyGood[1]` (or `supplyGood[2]`) is high. The output goes low one full stage delay later.
- R6: `delayCode[1:0]` sets stage 1, `delayCode[3:2]` sets stage 2, and `delayCode[5:4]` sets stage 3.
- R7: When `supplyGood[k]` is 0, `pupN[k]` and all higher bits are high one edge later, and lower stages are unaffected.
- R8: After a fault or an interrupted count, a stage waits its full delay from zero again.
- R9: `pupN[k]` is never low while `pupN[k-1]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 3 | Supply-good flags V0, V1, V2 (bit 0 = V0) |
| cascadeDis | input | 1 | 1 disables sequencing, 0 enables it |
| delayCode | input | 6 | Three 2-bit delay codes, stage 1 in the low bits |
| pupN | output | 3 | Active-low power-up enables, bit 0 = stage 1 |

## Verification
The bench sweeps all 64 delay-code combinations with every supply good at once. The cumulative arrival edge of each output separates the code decode and the field positions from the chaining. A staggered run raises V1 and V2 long after the previous stage has finished, so a delay measured from the supply can be told apart from one measured from the previous output. Fault runs drop V1 after full assertion, drop V0 during a count, and set the disable bit mid-operation. Together they show which stages release and that the counts restart from zero. Runs with V0 absent and with the disable bit set show that nothing starts.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int STAGES = 3;

  typedef struct packed {
    logic [STAGES-1:0] run;
    logic [STAGES-1:0] clear;
  } seqStrobes_t;
endpackage

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int TICK_DIV   = 250000,
  parameter int BASE_TICKS = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [2*STAGES-1:0] delayCode,
  output logic [STAGES-1:0] done
);
  localparam int SUB_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MAX_TICKS = BASE_TICKS * 8;
  localparam int MS_W = $clog2(MAX_TICKS + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICK_DIV - 1);
  localparam logic [MS_W-1:0] BASE_V = MS_W'(BASE_TICKS);

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    logic [SUB_W-1:0] subCnt;
    logic [MS_W-1:0]  msCnt;
    logic [MS_W-1:0]  target;
    logic             subWrap;

    assign target  = BASE_V << delayCode[2*g +: 2];
    assign subWrap = (subCnt == SUB_LAST);
    assign done[g] = strobes.run[g] && subWrap && (msCnt == target - MS_W'(1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        subCnt <= '0;
        msCnt  <= '0;
      end else if (strobes.clear[g]) begin
        subCnt <= '0;
        msCnt  <= '0;
      end else if (strobes.run[g]) begin
        if (subWrap) begin
          subCnt <= '0;
          msCnt  <= msCnt + MS_W'(1);
        end else begin
          subCnt <= subCnt + SUB_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAGES-1:0] supplyGood,
  input  logic              cascadeDis,
  input  logic [STAGES-1:0] done,
  output seqStrobes_t       strobes,
  output logic [STAGES-1:0] asserted
);
  logic [STAGES-1:0] live;
  logic [STAGES-1:0] prevOn;

  for (genvar g = 0; g < STAGES; g++) begin : gCtl
    if (g == 0) begin : gFirst
      assign live[g]   = !cascadeDis && supplyGood[g];
      assign prevOn[g] = 1'b1;
    end else begin : gLater
      assign live[g]   = live[g-1] && supplyGood[g];
      assign prevOn[g] = asserted[g-1];
    end

    assign strobes.run[g]   = live[g] && prevOn[g] && !asserted[g];
    assign strobes.clear[g] = !strobes.run[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) asserted[g] <= 1'b0;
      else       asserted[g] <= live[g] && (asserted[g] || done[g]);
    end
  end
endmodule

// File: rtl/pwr_cascade_seq.sv
module pwr_cascade_seq
  import pcs_pkg::*;
#(
  parameter int TICK_DIV   = 250000,
  parameter int BASE_TICKS = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] supplyGood,
  input  logic       cascadeDis,
  input  logic [5:0] delayCode,
  output logic [2:0] pupN
);
  seqStrobes_t       strobes;
  logic [STAGES-1:0] done;
  logic [STAGES-1:0] asserted;

  pcs_control u_ctl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .cascadeDis(cascadeDis),
    .done(done), .strobes(strobes), .asserted(asserted)
  );

  pcs_datapath #(.TICK_DIV(TICK_DIV), .BASE_TICKS(BASE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .delayCode(delayCode), .done(done)
  );

  assign pupN = ~asserted;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] supplyGood,
  input logic       cascadeDis,
  input logic [2:0] pupN
);
  a_r2_disable_forces_high: assert property (@(posedge clk) disable iff (!rstN)
    cascadeDis |=> (pupN == 3'b111));

  a_r3_no_start_without_v0: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood[0] |=> (pupN == 3'b111));

  a_r4_fall_needs_v0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pupN[0]) |-> ($past(supplyGood[0]) && !$past(cascadeDis)));

  a_r7_v1_fault: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood[1] |=> (pupN[2:1] == 2'b11));

  a_r7_v2_fault: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood[2] |=> pupN[2]);

  a_r8_hold_stage1: assert property (@(posedge clk) disable iff (!rstN)
    (!pupN[0] && supplyGood[0] && !cascadeDis) |=> !pupN[0]);

  a_r9_order_2: assert property (@(posedge clk) disable iff (!rstN)
    !pupN[1] |-> !pupN[0]);

  a_r9_order_3: assert property (@(posedge clk) disable iff (!rstN)
    !pupN[2] |-> !pupN[1]);
endmodule

bind pwr_cascade_seq pcs_checker u_chk (
  .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .cascadeDis(cascadeDis), .pupN(pupN)
);

// File: tb/test_pwr_cascade_seq.sv
`timescale 1ns/1ps
module test_pwr_cascade_seq;
  localparam int DIV  = 3;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] supplyGood = 3'b000;
  logic       cascadeDis = 1'b0;
  logic [5:0] delayCode = 6'd0;
  logic [2:0] pupN;

  int nChecks = 0;
  int nFails = 0;
  int firstLow [3];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwr_cascade_seq #(.TICK_DIV(DIV), .BASE_TICKS(BASE)) i_pwr_cascade_seq (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .cascadeDis(cascadeDis),
    .delayCode(delayCode), .pupN(pupN)
  );

  function automatic int stageCycles(input logic [1:0] code);
    return (BASE << code) * DIV;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int maxN);
    for (int k = 0; k < 3; k++) firstLow[k] = -1;
    for (int n = 1; n <= maxN; n++) begin
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < 3; k++)
        if (firstLow[k] < 0 && !pupN[k]) firstLow[k] = n;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int d0, d1, d2;
    // R1: reset state
    supplyGood = 3'b111;
    idle(3);
    check(pupN, 3'b111, "R1 during reset");
    @(negedge clk) rstN = 1'b1;
    supplyGood = 3'b000;
    idle(1);
    check(pupN, 3'b111, "R1 after reset");

    // R4 R5 R6: full sweep of all delay codes, supplies good together
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      supplyGood = 3'b000;
      delayCode  = 6'(c);
      idle(1);
      supplyGood = 3'b111;
      d0 = stageCycles(delayCode[1:0]);
      d1 = stageCycles(delayCode[3:2]);
      d2 = stageCycles(delayCode[5:4]);
      measure(d0 + d1 + d2 + 4);
      check(firstLow[0], d0, $sformatf("R4 R6 stage1 code=%0d", c));
      check(firstLow[1], d0 + d1, $sformatf("R5 R6 stage2 code=%0d", c));
      check(firstLow[2], d0 + d1 + d2, $sformatf("R5 R6 stage3 code=%0d", c));
    end

    // R3: V0 absent, later supplies good
    @(negedge clk);
    supplyGood = 3'b000;
    delayCode  = 6'b000000;
    idle(1);
    supplyGood = 3'b110;
    measure(100);
    check(firstLow[0], -1, "R3 stage1 idle without V0");
    check(firstLow[2], -1, "R3 stage3 idle without V0");

    // R2: disabled with all supplies good
    cascadeDis = 1'b1;
    supplyGood = 3'b111;
    measure(100);
    check(firstLow[0], -1, "R2 disabled stage1");
    check(firstLow[1], -1, "R2 disabled stage2");

    // R5: staggered supplies, delays from the supply rise
    cascadeDis = 1'b0;
    supplyGood = 3'b000;
    delayCode  = 6'b10_01_00;
    idle(1);
    supplyGood = 3'b001;
    measure(40);
    check(firstLow[0], stageCycles(2'd0), "R5 stagger stage1");
    check(firstLow[1], -1, "R5 stage2 waits for V1");
    supplyGood = 3'b011;
    measure(stageCycles(2'd1) + 2);
    check(firstLow[1], stageCycles(2'd1), "R5 stagger stage2 from V1");
    check(firstLow[2], -1, "R5 stage3 waits for V2");
    supplyGood = 3'b111;
    measure(stageCycles(2'd2) + 2);
    check(firstLow[2], stageCycles(2'd2), "R5 stagger stage3 from V2");

    // R7 R8: V1 drop after full assertion
    delayCode  = 6'b00_10_01;
    supplyGood = 3'b101;
    idle(1);
    check(pupN, 3'b110, "R7 V1 drop releases stages 2 and 3");
    idle(4);
    check(pupN, 3'b110, "R7 stage1 kept during V1 fault");
    supplyGood = 3'b111;
    measure(stageCycles(2'd2) + stageCycles(2'd0) + 3);
    check(firstLow[1], stageCycles(2'd2), "R8 stage2 restarts from zero");
    check(firstLow[2], stageCycles(2'd2) + stageCycles(2'd0), "R8 stage3 restarts");

    // R8: V0 glitch during stage 1 count
    supplyGood = 3'b000;
    delayCode  = 6'b00_00_10;
    idle(1);
    supplyGood = 3'b111;
    idle(10);
    supplyGood = 3'b000;
    idle(2);
    supplyGood = 3'b111;
    measure(stageCycles(2'd2) + 2);
    check(firstLow[0], stageCycles(2'd2), "R8 stage1 full delay after glitch");

    // R2: disable while outputs are asserted
    idle(40);
    check(pupN, 3'b000, "R2 precondition all asserted");
    cascadeDis = 1'b1;
    idle(1);
    check(pupN, 3'b111, "R2 disable releases all");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule